// File: doc/BRIEF.md
# Long-Size Shift and Rotate Unit with Exact Condition Codes

This block is the shift and rotate execution unit of a 32-bit load-store core whose software emulates an older CISC instruction set. It takes a 32-bit operand, a 6-bit shift count and a 3-bit operation code. It returns the 32-bit result and the five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). The flags follow the long-size shift and rotate rules of that instruction set bit for bit, so the emulator can copy them straight into its status image without fixing them up in software. Byte and word sizes, and rotates through the extend bit, are left to software.

The datapath works on a single 64-bit product. It computes the operand times 2^k, with k between 0 and 32. Left shifts take the low half of the product, and the high half holds the bits shifted out. A right shift by n uses k = 32 - n and takes the high half. A rotate ORs the two halves together. The parameter `USE_MULT` sets how the product is built. When it is 1, an ordinary multiplier builds it, and synthesis can map that multiplier to a hard DSP block. When it is 0, a logarithmic mux tree builds it. Both settings give identical results.

The parameter `REG_OUT` adds a clock-enabled output register. When `REG_OUT` is 0, the unit is purely combinational.

Top module: `lw_shift_unit`

## Requirements
- R1: The operation code selects the function as follows: 0 is logical left (LSL), 1 is logical right (LSR), 2 is arithmetic left (ASL), 3 is arithmetic right (ASR), 4 is rotate left (ROL) and 5 is rotate right (ROR). LSL and LSR fill with zeros, and a count of 32 or more gives a zero result.
- R2: ASR fills the vacated bits with operand bit 31. A count of 32 or more gives 32 copies of that bit.
- R3: ROL and ROR rotate by the count modulo 32. A nonzero count that is a multiple of 32 returns the operand unchanged.
- R4: A count of 0 returns the operand unchanged for every legal code. C and V are 0, X equals `x_i`, and N and Z come from the operand.
- R5: For LSL, LSR, ASL and ASR with a nonzero count, C and X both equal the last bit shifted out. A count of exactly 32 shifts out operand bit 0 (left shifts) or operand bit 31 (right shifts). For a count above 32, C and X are 0 for LSL, LSR and ASL, and equal operand bit 31 for ASR.
- R6: ASL sets V when bit 31 changes value after any single step of the shift. V is 0 otherwise.
- R7: LSL, LSR and ASR always leave V at 0.
- R8: For ROL and ROR, X equals `x_i` and V is 0. With a nonzero count, C equals result bit 0 for ROL and result bit 31 for ROR.
- R9: N equals result bit 31. Z is 1 exactly when all 32 result bits are 0.
- R10: Codes 6 and 7 set `illegal_o` to 1 and return the operand unchanged. C and V are 0, X equals `x_i`, and N and Z come from the operand. Codes 0 to 5 set `illegal_o` to 0.
- R11: `USE_MULT` = 1 and `USE_MULT` = 0 give identical outputs for every input.
- R12: With `REG_OUT` = 1, the outputs load on a rising clock edge while `en` is 1 and hold while `en` is 0. An active reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the output register |
| op_i | input | 3 | Operation code (see R1) |
| cnt_i | input | 6 | Shift count, 0 to 63 |
| opnd_i | input | 32 | Operand |
| x_i | input | 1 | Current extend flag |
| res_o | output | 32 | Result |
| x_o | output | 1 | Extend flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |
| illegal_o | output | 1 | Unsupported operation code |

## Verification
The bench builds two copies of the unit side by side. The first uses the default multiplier datapath with the output register (`USE_MULT` = 1, `REG_OUT` = 1). The second uses the mux-tree datapath with no register (`USE_MULT` = 0, `REG_OUT` = 0). Both copies are checked against a reference model that shifts one bit per step. Running two copies lets a single sweep of every operation code and every count from 0 to 63 test the equivalence of the two datapaths. The same sweep also covers the boundary counts 0, 31, 32 and 33. The registered copy also brings the reset values and the hold behaviour of the enable into reach.

// File: rtl/lw_shift_pkg.sv
package lw_shift_pkg;
  localparam logic [2:0] OP_LSL = 3'd0;
  localparam logic [2:0] OP_LSR = 3'd1;
  localparam logic [2:0] OP_ASL = 3'd2;
  localparam logic [2:0] OP_ASR = 3'd3;
  localparam logic [2:0] OP_ROL = 3'd4;
  localparam logic [2:0] OP_ROR = 3'd5;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/lw_shift_mul_core.sv
module lw_shift_mul_core #(
  parameter int W  = 32,
  parameter int KW = $clog2(W) + 1
) (
  input  logic [W-1:0]   a_i,
  input  logic [KW-1:0]  k_i,
  output logic [2*W-1:0] wide_o
);
  localparam int PW = 2 * W;

  logic [W:0]    pow2;
  logic [PW-1:0] prod;

  // Power of two for the scale factor; k never exceeds W.
  assign pow2   = (W + 1)'(1) << k_i;
  assign prod   = PW'(a_i) * PW'(pow2);
  assign wide_o = prod;
endmodule

// File: rtl/lw_shift_mux_core.sv
module lw_shift_mux_core #(
  parameter int W  = 32,
  parameter int KW = $clog2(W) + 1
) (
  input  logic [W-1:0]   a_i,
  input  logic [KW-1:0]  k_i,
  output logic [2*W-1:0] wide_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] stage [KW+1];

  assign stage[0] = {{W{1'b0}}, a_i};

  for (genvar s = 0; s < KW; s++) begin : g_stage
    assign stage[s+1] = k_i[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign wide_o = stage[KW];
endmodule

// File: rtl/lw_shift_ctrl.sv
module lw_shift_ctrl
  import lw_shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int KW = $clog2(W) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     op_i,
  input  logic [KW-1:0]  cnt_i,
  input  logic [W-1:0]   a_i,
  input  logic           x_i,
  output logic [KW-1:0]  k_o,
  input  logic [2*W-1:0] wide_i,
  output logic [W-1:0]   res_o,
  output ccr_t           ccr_o,
  output logic           illegal_o
);
  localparam logic [KW-1:0] W_K  = KW'(W);
  localparam logic [KW:0]   W_K1 = (KW + 1)'(W);

  logic [W-1:0]  lo, hi, res;
  logic          sign, zero_cnt, big, over, c, v, x, ill;
  logic [KW:0]   right_k, ror_k;

  // Bits at or above position t set.
  function automatic logic [W-1:0] up_mask(input int t);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i >= t);
    return m;
  endfunction

  assign lo       = wide_i[W-1:0];
  assign hi       = wide_i[2*W-1:W];
  assign sign     = a_i[W-1];
  assign zero_cnt = (cnt_i == '0);
  assign big      = (cnt_i >= W_K);
  assign over     = (cnt_i > W_K);
  assign right_k  = W_K1 - {1'b0, cnt_i};
  assign ror_k    = W_K1 - {2'b0, cnt_i[KW-2:0]};

  // Scale selection for the shared product.
  always_comb begin
    unique case (op_i)
      OP_LSL, OP_ASL: k_o = big ? W_K : cnt_i;
      OP_LSR, OP_ASR: k_o = big ? '0 : right_k[KW-1:0];
      OP_ROL:         k_o = {1'b0, cnt_i[KW-2:0]};
      OP_ROR:         k_o = ror_k[KW-1:0];
      default:        k_o = '0;
    endcase
  end

  // Result and flag selection.
  always_comb begin
    res = a_i;
    c   = 1'b0;
    v   = 1'b0;
    x   = x_i;
    ill = 1'b0;
    unique case (op_i)
      OP_LSL, OP_ASL: begin
        res = over ? '0 : lo;
        c   = over ? 1'b0 : wide_i[W];
        x   = c;
        if (op_i == OP_ASL)
          v = big ? (|a_i)
                  : (|((a_i ^ {W{sign}}) & up_mask(W - 1 - int'(cnt_i))));
      end
      OP_LSR: begin
        res = over ? '0 : hi;
        c   = over ? 1'b0 : wide_i[W-1];
        x   = c;
      end
      OP_ASR: begin
        res = over ? {W{sign}}
                   : (hi | (sign ? up_mask(int'(k_o)) : '0));
        c   = over ? sign : wide_i[W-1];
        x   = c;
      end
      OP_ROL: begin
        res = hi | lo;
        c   = res[0];
      end
      OP_ROR: begin
        res = hi | lo;
        c   = res[W-1];
      end
      default: ill = 1'b1;
    endcase
    if (zero_cnt) begin
      res = a_i;
      c   = 1'b0;
      v   = 1'b0;
      x   = x_i;
    end
  end

  assign res_o     = res;
  assign illegal_o = ill;
  assign ccr_o     = '{x: x, n: res[W-1], z: (res == '0), v: v, c: c};

  // R4
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_cnt && op_i <= OP_ROR) |->
      (res_o == a_i && !ccr_o.c && !ccr_o.v && ccr_o.x == x_i));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LSL || op_i == OP_LSR || op_i == OP_ASR) |-> !ccr_o.v);

  // R8
  rotate_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ROL || op_i == OP_ROR) |-> (ccr_o.x == x_i && !ccr_o.v));

  // R5
  shift_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= OP_ASR && !zero_cnt) |-> (ccr_o.x == ccr_o.c));

  // R10
  illegal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > OP_ROR) |-> (illegal_o && res_o == a_i && !ccr_o.c && !ccr_o.v));
endmodule

// File: rtl/lw_shift_unit.sv
module lw_shift_unit
  import lw_shift_pkg::*;
#(
  parameter int  DATA_W   = 32,
  parameter bit  USE_MULT = 1'b1,
  parameter bit  REG_OUT  = 1'b1,
  localparam int CNT_W    = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              x_i,
  output logic [DATA_W-1:0] res_o,
  output logic              x_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              illegal_o
);
  localparam int OUT_W = DATA_W + 6;

  logic [CNT_W-1:0]    k;
  logic [2*DATA_W-1:0] wide;
  logic [DATA_W-1:0]   res_c;
  ccr_t                ccr_c;
  logic                ill_c;
  logic [OUT_W-1:0]    out_c, out_q;

  if (USE_MULT) begin : g_mul
    lw_shift_mul_core #(.W(DATA_W), .KW(CNT_W)) u_core (
      .a_i(opnd_i), .k_i(k), .wide_o(wide));
  end else begin : g_mux
    lw_shift_mux_core #(.W(DATA_W), .KW(CNT_W)) u_core (
      .a_i(opnd_i), .k_i(k), .wide_o(wide));
  end

  lw_shift_ctrl #(.W(DATA_W), .KW(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .cnt_i    (cnt_i),
    .a_i      (opnd_i),
    .x_i      (x_i),
    .k_o      (k),
    .wide_i   (wide),
    .res_o    (res_c),
    .ccr_o    (ccr_c),
    .illegal_o(ill_c)
  );

  assign out_c = {ill_c, ccr_c, res_c};

  if (REG_OUT) begin : g_reg
    logic [OUT_W-1:0] out_d;

    always_comb begin
      out_d = out_q;
      if (en) out_d = out_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= out_d;
    end

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(out_q));
  end else begin : g_comb
    assign out_q = out_c;
  end

  assign {illegal_o, x_o, n_o, z_o, v_o, c_o, res_o} = out_q;
endmodule

// File: tb/lw_shift_unit_bench.sv
`timescale 1ns/1ps
module lw_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [5:0]  cnt = 6'd0;
  logic [31:0] opnd = 32'd0;
  logic        xin = 1'b0;

  logic [31:0] r_res, m_res;
  logic        r_x, r_n, r_z, r_v, r_c, r_ill;
  logic        m_x, m_n, m_z, m_v, m_c, m_ill;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lw_shift_unit #(.DATA_W(32), .USE_MULT(1'b1), .REG_OUT(1'b1)) u_lw_shift_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .op_i(op), .cnt_i(cnt), .opnd_i(opnd),
    .x_i(xin), .res_o(r_res), .x_o(r_x), .n_o(r_n), .z_o(r_z), .v_o(r_v),
    .c_o(r_c), .illegal_o(r_ill));

  lw_shift_unit #(.DATA_W(32), .USE_MULT(1'b0), .REG_OUT(1'b0)) u_lw_shift_unit_mux (
    .clk(clk), .rst_n(rst_n), .en(en), .op_i(op), .cnt_i(cnt), .opnd_i(opnd),
    .x_i(xin), .res_o(m_res), .x_o(m_x), .n_o(m_n), .z_o(m_z), .v_o(m_v),
    .c_o(m_c), .illegal_o(m_ill));

  // Reference: one bit per step. Packed as {ill, x, n, z, v, c, res}.
  function automatic logic [37:0] model(input logic [2:0] o, input logic [5:0] n,
                                        input logic [31:0] a, input logic xi);
    logic [31:0] r;
    logic c, v, x, ill, old;
    r = a; c = 1'b0; v = 1'b0; x = xi; ill = (o > 3'd5);
    if (!ill) begin
      for (int i = 0; i < int'(n); i++) begin
        old = r[31];
        case (o)
          3'd0, 3'd2: begin c = r[31]; r = r << 1; if (o == 3'd2 && r[31] != old) v = 1'b1; end
          3'd1: begin c = r[0]; r = r >> 1; end
          3'd3: begin c = r[0]; r = {r[31], r[31:1]}; end
          3'd4: begin c = r[31]; r = {r[30:0], r[31]}; end
          default: begin c = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
      if (n != 6'd0 && o <= 3'd3) x = c;
    end
    return {ill, x, r[31], (r == 32'd0), v, c, r};
  endfunction

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (op=%0d cnt=%0d a=%h x=%b)",
               tag, act, exp, op, cnt, opnd, xin);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the loading edge.
  task automatic apply(input string tag, input logic [2:0] o, input logic [5:0] n,
                       input logic [31:0] a, input logic xi);
    logic [37:0] e;
    @(negedge clk);
    op = o; cnt = n; opnd = a; xin = xi; en = 1'b1;
    @(posedge clk);
    #1;
    e = model(o, n, a, xi);
    check({tag, " reg"}, {r_ill, r_x, r_n, r_z, r_v, r_c, r_res}, e);
    check({tag, " mux"}, {m_ill, m_x, m_n, m_z, m_v, m_c, m_res}, e);
  endtask

  task automatic t_reset;
    #1;
    check("R12 reset", {r_ill, r_x, r_n, r_z, r_v, r_c, r_res}, 38'd0);
  endtask

  task automatic t_zero;
    apply("R4 zero lsl", 3'd0, 6'd0, 32'h8000_0001, 1'b1);
    apply("R4 zero asr", 3'd3, 6'd0, 32'h0000_0000, 1'b0);
    apply("R4 zero ror", 3'd5, 6'd0, 32'hF000_0000, 1'b1);
    apply("R9 zero flag", 3'd1, 6'd0, 32'h0, 1'b1);
  endtask

  task automatic t_logical;
    apply("R1 lsl 4", 3'd0, 6'd4, 32'h1234_5678, 1'b0);
    apply("R1 lsr 4", 3'd1, 6'd4, 32'h1234_5678, 1'b1);
    apply("R5 lsl 32", 3'd0, 6'd32, 32'h0000_0001, 1'b0);
    apply("R5 lsr 32", 3'd1, 6'd32, 32'h8000_0000, 1'b0);
    apply("R5 lsl 33", 3'd0, 6'd33, 32'hFFFF_FFFF, 1'b1);
    apply("R5 lsr 63", 3'd1, 6'd63, 32'hFFFF_FFFF, 1'b1);
    apply("R9 lsr to zero", 3'd1, 6'd1, 32'h0000_0001, 1'b0);
  endtask

  task automatic t_arith;
    apply("R6 asl ovf", 3'd2, 6'd1, 32'h4000_0000, 1'b0);
    apply("R6 asl no ovf", 3'd2, 6'd3, 32'hF000_0000, 1'b0);
    apply("R6 asl 31 ones", 3'd2, 6'd31, 32'hFFFF_FFFF, 1'b0);
    apply("R6 asl 32 ones", 3'd2, 6'd32, 32'hFFFF_FFFF, 1'b0);
    apply("R2 asr neg", 3'd3, 6'd8, 32'h8000_00F0, 1'b0);
    apply("R2 asr 40 neg", 3'd3, 6'd40, 32'h8000_0000, 1'b0);
    apply("R7 asr pos", 3'd3, 6'd5, 32'h7FFF_FFFF, 1'b1);
  endtask

  task automatic t_rotate;
    apply("R3 rol 8", 3'd4, 6'd8, 32'h8100_00FF, 1'b1);
    apply("R3 ror 8", 3'd5, 6'd8, 32'h8100_00FF, 1'b0);
    apply("R8 rol 32", 3'd4, 6'd32, 32'h0000_0001, 1'b1);
    apply("R8 ror 33", 3'd5, 6'd33, 32'h0000_0001, 1'b0);
  endtask

  task automatic t_illegal;
    apply("R10 code6", 3'd6, 6'd5, 32'hDEAD_BEEF, 1'b1);
    apply("R10 code7", 3'd7, 6'd0, 32'h0000_0000, 1'b0);
  endtask

  task automatic t_hold;
    logic [37:0] held;
    apply("R12 load", 3'd0, 6'd1, 32'h0000_0003, 1'b0);
    held = model(3'd0, 6'd1, 32'h0000_0003, 1'b0);
    @(negedge clk);
    en = 1'b0; op = 3'd1; cnt = 6'd2; opnd = 32'hFFFF_0000;
    @(posedge clk);
    #1;
    check("R12 hold", {r_ill, r_x, r_n, r_z, r_v, r_c, r_res}, held);
    check("R12 comb follows", {m_ill, m_x, m_n, m_z, m_v, m_c, m_res},
          model(3'd1, 6'd2, 32'hFFFF_0000, 1'b0));
  endtask

  task automatic t_sweep;
    logic [31:0] pats [3];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7A5C_3E91; pats[2] = 32'hC000_0000;
    for (int p = 0; p < 3; p++)
      for (int o = 0; o < 6; o++)
        for (int n = 0; n < 64; n++) begin
          apply("R11 sweep", 3'(o), 6'(n), pats[p], 1'(n % 2));
          checks++;
          if ({r_ill, r_x, r_n, r_z, r_v, r_c, r_res} !== {m_ill, m_x, m_n, m_z, m_v, m_c, m_res}) begin
            errors++;
            $display("FAIL R11 mult=%h mux=%h", {r_ill, r_x, r_n, r_z, r_v, r_c, r_res},
                     {m_ill, m_x, m_n, m_z, m_v, m_c, m_res});
          end
        end
  endtask

  initial begin
    fork
      begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_zero;
    t_logical;
    t_arith;
    t_rotate;
    t_illegal;
    t_hold;
    t_sweep;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule